// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codec for a 16-Bit Memory Word

This block protects a 16-bit memory word with six group check bits and one overall check bit, 23 stored bits in all. Its write side is purely combinational. It takes the data about to be stored and produces the seven check bits that are stored with it. Each group check bit is the parity of a fixed subset of the data bits. The highest group covers exactly the upper data byte. The overall bit makes the parity of the whole 23-bit word even.

The read side is also combinational. It takes the 23 stored bits back, recomputes the six group parities and forms a six-bit syndrome. The overall syndrome is not built from a second full-width tree. It is assembled from three parts: syndrome bit 5, which already holds the parity of the upper data byte and its check bit; the parity of the lower data byte; and the parity of the remaining stored check bits. From the syndrome and the overall syndrome the decoder reports one of three outcomes. When it reports a correctable error it inverts the single faulty data bit.

Encoder and decoder share no state. A write and an unrelated read can be served in the same cycle.

Top module: `secded16_codec`

## Requirements
- R1: For k = 0..5, wr_check[k] is the XOR of the wr_data bits whose column code has bit k set. The column codes in decimal are 3, 5, 6, 7, 9, 10, 11, 12 for data bits 0..7 and 33, 34, 35, 36, 37, 38, 39, 40 for data bits 8..15.
- R2: Check bit 5 (wr_check[5]) depends on data bits 8..15 and on no other data bit.
- R3: wr_check[6] is chosen so that the XOR of all 16 data bits and all 7 check bits is zero.
- R4: A stored word {rd_check, rd_data} that equals a valid encoding reads back with rd_status = 0 and rd_fixed equal to rd_data.
- R5: rd_status uses the encoding 0 = no error, 1 = single error corrected, 2 = uncorrectable. The value 3 never appears.
- R6: When exactly one data bit of a valid word is inverted, rd_status is 1 and rd_fixed equals the original data. rd_fixed differs from rd_data in at most one bit.
- R7: When exactly one stored check bit is inverted (any of rd_check[6:0]), rd_status is 1 and rd_fixed equals rd_data.
- R8: When any two of the 23 stored bits are inverted, rd_status is 2 and rd_fixed equals rd_data.
- R9: When data bit 7, check bit 0 and check bit 1 are inverted together, the syndrome matches no column. rd_status is 2 and rd_fixed equals rd_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_data | input | 16 | Data word to be stored |
| wr_check | output | 7 | Check bits for wr_data: [5:0] group parities, [6] overall parity |
| rd_data | input | 16 | Data part of the word read from memory |
| rd_check | input | 7 | Check part of the word read from memory |
| rd_fixed | output | 16 | Read data after correction |
| rd_status | output | 2 | Read outcome: 0 clean, 1 corrected, 2 uncorrectable |

## Verification
Check-bit generation and read-side correction are both combinational and can be exercised in the same cycle. Every stimulus cycle therefore drives a fresh pseudo-random write word alongside a read word, and that read word comes from an unrelated data value with a chosen error mask applied. The scoreboard judges wr_check against a bench encoder and judges rd_fixed and rd_status against the known error mask, all in the same cycle. This exposes any coupling between the write path and the read path. The read cases sweep every single-bit position across all 23 stored bits, a set of double errors, and one triple error whose syndrome matches no column.

// File: rtl/secded16_pkg.sv
package secded16_pkg;

   // Read outcome encoding
   typedef enum logic [1:0] {
      ST_CLEAN = 2'd0,
      ST_FIXED = 2'd1,
      ST_FATAL = 2'd2
   } ecc_status_e;

   // Column code of data bit idx for a code with dw data bits and gw groups.
   // Lower half: top group bit clear, weight >= 2, ascending order.
   // Upper half: top group bit set, weight >= 2, ascending order.
   function automatic logic [15:0] col_code(input int idx, input int dw, input int gw);
      int want;
      int seen;
      int hi;
      logic [15:0] r;
      hi   = (idx >= dw / 2) ? 1 : 0;
      want = (hi == 1) ? idx - dw / 2 : idx;
      seen = 0;
      r    = '0;
      for (int v = 1; v < (1 << gw); v++) begin
         if ((((v >> (gw - 1)) & 1) == hi) && ($countones(v) >= 2)) begin
            if (seen == want && r == '0) r = 16'(v);
            seen++;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/secded_group_parity.sv
module secded_group_parity #(
   parameter int DATA_W = 16,
   parameter int GRP_W  = 6
) (
   input  logic [DATA_W-1:0] data,
   output logic [GRP_W-1:0]  par
);
   localparam int HALF_W = DATA_W / 2;
   localparam int LOW_CODES = (1 << (GRP_W - 1)) - GRP_W;

   if (GRP_W > 16 || GRP_W < 3) begin : g_bad_grp
      $error("GRP_W out of range");
   end
   if (DATA_W % 2 != 0 || HALF_W > LOW_CODES) begin : g_bad_data
      $error("DATA_W must be even and fit the column space");
   end

   for (genvar k = 0; k < GRP_W; k++) begin : g_grp
      logic [DATA_W-1:0] mask;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam logic [15:0] CODE = secded16_pkg::col_code(i, DATA_W, GRP_W);
         assign mask[i] = CODE[k];
      end
      assign par[k] = ^(data & mask);
   end
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
   parameter int DATA_W         = 16,
   parameter int GRP_W          = 6,
   parameter bit SHARED_OVERALL = 1'b1
) (
   input  logic [DATA_W-1:0] rd_data,
   input  logic [GRP_W:0]    rd_check,
   output logic [GRP_W-1:0]  syn,
   output logic              syn_all
);
   localparam int HALF_W = DATA_W / 2;

   logic [GRP_W-1:0] regen;

   secded_group_parity #(.DATA_W(DATA_W), .GRP_W(GRP_W)) i_regen (
      .data (rd_data),
      .par  (regen)
   );

   assign syn = regen ^ rd_check[GRP_W-1:0];

   if (SHARED_OVERALL) begin : g_shared
      // top syndrome bit already folds in the upper byte and its check bit
      assign syn_all = syn[GRP_W-1] ^ (^rd_data[HALF_W-1:0])
                     ^ (^rd_check[GRP_W-2:0]) ^ rd_check[GRP_W];
   end else begin : g_full
      assign syn_all = (^rd_data) ^ (^rd_check);
   end
endmodule

// File: rtl/secded_classify.sv
module secded_classify #(
   parameter int DATA_W = 16,
   parameter int GRP_W  = 6
) (
   input  logic [GRP_W-1:0]         syn,
   input  logic                     syn_all,
   output secded16_pkg::ecc_status_e status,
   output logic [DATA_W-1:0]        flip
);
   import secded16_pkg::*;

   logic [DATA_W-1:0] hit_vec;
   logic              data_hit;
   logic              chk_hit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_match
      localparam logic [15:0] CODE = col_code(i, DATA_W, GRP_W);
      assign hit_vec[i] = (syn == CODE[GRP_W-1:0]);
   end

   assign flip     = syn_all ? hit_vec : '0;
   assign data_hit = |hit_vec;

   always_comb begin
      chk_hit = syn_all && ($countones(syn) <= 1);
      if (!syn_all && syn == '0)            status = ST_CLEAN;
      else if (syn_all && (data_hit || chk_hit)) status = ST_FIXED;
      else                                  status = ST_FATAL;
   end

   always_comb begin
      // R6
      flip_onehot_chk: assert ($onehot0(flip));
      // R8
      fatal_noflip_chk: assert (status != ST_FATAL || flip == '0);
   end
endmodule

// File: rtl/secded16_codec.sv
module secded16_codec #(
   parameter int DATA_W         = 16,
   parameter int GRP_W          = 6,
   parameter bit SHARED_OVERALL = 1'b1
) (
   input  logic [DATA_W-1:0] wr_data,
   output logic [GRP_W:0]    wr_check,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [GRP_W:0]    rd_check,
   output logic [DATA_W-1:0] rd_fixed,
   output logic [1:0]        rd_status
);
   import secded16_pkg::*;

   logic [GRP_W-1:0]  enc_par;
   logic [GRP_W-1:0]  syn;
   logic              syn_all;
   ecc_status_e       status;
   logic [DATA_W-1:0] flip;

   secded_group_parity #(.DATA_W(DATA_W), .GRP_W(GRP_W)) i_enc (
      .data (wr_data),
      .par  (enc_par)
   );

   assign wr_check = {(^wr_data) ^ (^enc_par), enc_par};

   secded_syndrome #(
      .DATA_W(DATA_W), .GRP_W(GRP_W), .SHARED_OVERALL(SHARED_OVERALL)
   ) i_syn (
      .rd_data  (rd_data),
      .rd_check (rd_check),
      .syn      (syn),
      .syn_all  (syn_all)
   );

   secded_classify #(.DATA_W(DATA_W), .GRP_W(GRP_W)) i_cls (
      .syn     (syn),
      .syn_all (syn_all),
      .status  (status),
      .flip    (flip)
   );

   assign rd_fixed  = rd_data ^ flip;
   assign rd_status = status;

   always_comb begin
      // R5
      status_code_chk: assert (rd_status != 2'b11);
      // R6
      fix_weight_chk: assert ($countones(rd_fixed ^ rd_data) <= 1);
      // R4
      clean_pass_chk: assert (rd_status != ST_CLEAN || rd_fixed == rd_data);
      // R8
      fatal_pass_chk: assert (rd_status != ST_FATAL || rd_fixed == rd_data);
   end
endmodule

// File: tb/test_secded16_codec.sv
module test_secded16_codec;

   typedef struct {
      logic [6:0]  exp_check;
      logic [15:0] exp_fixed;
      logic [1:0]  exp_status;
      int          tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] wr_data = '0;
   logic [6:0]  wr_check;
   logic [15:0] rd_data = '0;
   logic [6:0]  rd_check = '0;
   logic [15:0] rd_fixed;
   logic [1:0]  rd_status;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;
   item_t sb_q[$];
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;   // 200 MHz

   secded16_codec i_secded16_codec (
      .wr_data   (wr_data),
      .wr_check  (wr_check),
      .rd_data   (rd_data),
      .rd_check  (rd_check),
      .rd_fixed  (rd_fixed),
      .rd_status (rd_status)
   );

   // column codes per R1
   function automatic logic [5:0] code_of(input int i);
      logic [5:0] tbl [16];
      tbl = '{6'd3, 6'd5, 6'd6, 6'd7, 6'd9, 6'd10, 6'd11, 6'd12,
              6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd39, 6'd40};
      return tbl[i];
   endfunction

   // bench encoder: R1, R2 groups, R3 overall even parity
   function automatic logic [6:0] model_enc(input logic [15:0] d);
      logic [6:0] c;
      c = '0;
      for (int k = 0; k < 6; k++)
         for (int i = 0; i < 16; i++)
            if (code_of(i)[k]) c[k] = c[k] ^ d[i];
      c[6] = (^d) ^ (^c[5:0]);
      return c;
   endfunction

   function automatic logic [15:0] next_lfsr(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   // driver: bit positions 0..15 data, 16..22 check bits 0..6
   task automatic send(input logic [15:0] word, input logic [22:0] emask, input int tag);
      logic [22:0] stored;
      item_t it;
      int nerr;
      stored = {model_enc(word), word} ^ emask;
      nerr = $countones(emask);
      @(negedge clk);
      lfsr    = next_lfsr(lfsr);
      wr_data = lfsr;
      rd_data  = stored[15:0];
      rd_check = stored[22:16];
      it.exp_check = model_enc(lfsr);
      it.tag = tag;
      if (nerr == 0) begin
         it.exp_status = 2'd0; it.exp_fixed = word;          // R4
      end else if (nerr == 1) begin
         it.exp_status = 2'd1; it.exp_fixed = word;          // R6, R7
      end else begin
         it.exp_status = 2'd2; it.exp_fixed = stored[15:0];  // R8, R9
      end
      sb_q.push_back(it);
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_checks++;
         if (wr_check[5:0] !== it.exp_check[5:0]) begin
            n_fails++;
            $display("FAIL R1,R2 group checks: actual %h expected %h", wr_check[5:0], it.exp_check[5:0]);
         end
         n_checks++;
         if (wr_check[6] !== it.exp_check[6]) begin
            n_fails++;
            $display("FAIL R3 overall check: actual %b expected %b", wr_check[6], it.exp_check[6]);
         end
         n_checks++;
         if (rd_status !== it.exp_status || rd_status === 2'b11) begin
            n_fails++;
            $display("FAIL R%0d (R5 encoding) status: actual %0d expected %0d", it.tag, rd_status, it.exp_status);
         end
         n_checks++;
         if (rd_fixed !== it.exp_fixed) begin
            n_fails++;
            $display("FAIL R%0d data: actual %h expected %h", it.tag, rd_fixed, it.exp_fixed);
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      rst = 1'b0;
      // reset state: all-zero inputs read as clean, zero check bits (R4, R5)
      send(16'h0000, 23'd0, 4);
      // clean words with concurrent writes (R1, R2, R3, R4)
      send(16'hFFFF, 23'd0, 4);
      send(16'h00FF, 23'd0, 4);
      send(16'hFF00, 23'd0, 4);
      send(16'h1234, 23'd0, 4);
      // every single-bit position on two data values (R6 data, R7 check)
      for (int b = 0; b < 23; b++) send(16'hA5C3, 23'd1 << b, (b < 16) ? 6 : 7);
      for (int b = 0; b < 23; b++) send(16'h3C69, 23'd1 << b, (b < 16) ? 6 : 7);
      // double errors across data, check and mixed positions (R8)
      for (int a = 0; a < 23; a++) send(16'h5A0F, (23'd1 << a) | (23'd1 << ((a + 7) % 23)), 8);
      send(16'h8001, 23'h000003, 8);   // two low-byte data bits
      send(16'h8001, 23'h00C000, 8);   // two high-byte data bits
      send(16'h8001, 23'h410000, 8);   // check 0 and overall check
      // triple error with no matching column: D7, C0, C1 (R9)
      send(16'h7E81, (23'd1 << 7) | (23'd1 << 16) | (23'd1 << 17), 9);
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

endmodule